// File: doc/BRIEF.md
# Bit-Serial-Stage Pipelined Adder Stream

This block adds a run of 4-bit operand pairs held in two small operand stores and places each sum in a result store at the same index. Its carry chain is cut by a register after every full-adder cell, so each bit position of the sum is formed in its own clock stage. Once the pipe has filled, the block accepts a new pair and retires a finished sum on every clock. Every 4-bit sum takes the same fixed number of clocks to pass through.

Between cells, each stage register carries forward the operand bits that are still unused, the carry out of the cell behind it, and the sum bits already formed. The operand bits shift down one place per stage, so each cell always consumes bit 0. The sum bits shift in from the top, so they line up again after the last cell. The index of each pair and a valid/last marker ride along with the data, and the write into the result store uses that carried index.

Software fills the operand stores through a load port and pulses start with a pair count. It waits for done and then reads results through a registered read port.

Top module: `bpa_top`

## Requirements
- R1: After a run over N pairs, result entry i for every i < N equals (A[i] + B[i]) mod 16. The carry into bit 0 is zero and the carry out of bit 3 is discarded. A and B entries are written at index ld_idx on each clock where ld_en is high.
- R2: When start is accepted at a clock edge (counted as edge 0) with an effective count N ≥ 1, done is low after edges 1 through N+4 and high after edge N+5. This gives one result per clock after a fill of five clocks.
- R3: An accepted start with a count of at least 1 clears done at the accepting edge. Once done is high it stays high, and the result store is not written, until the next accepted start.
- R4: An accepted start with a count of 0 sets done at the accepting edge, leaves busy low and writes no result entry.
- R5: A run over N pairs leaves every result entry with an index of N or above unchanged.
- R6: A start pulse while busy is high is ignored. The run in flight completes with its original count and timing.
- R7: While reset is held and after it is released, done and busy are low until a start is accepted.
- R8: rd_sum shows the result entry addressed by rd_idx one clock edge after rd_idx is presented. It does not change between edges.
- R9: busy is high from the edge that accepts a start with count ≥ 1 until the edge that writes the last result, and low from then on.
- R10: A count larger than 16 is treated as 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Write strobe for both operand stores |
| ld_idx | input | 4 | Operand store index to write |
| ld_a | input | 4 | Value written to the A store |
| ld_b | input | 4 | Value written to the B store |
| start | input | 1 | Begin a run when not busy |
| count | input | 5 | Number of pairs in the run (clamped to 16) |
| rd_idx | input | 4 | Result store index to read |
| rd_sum | output | 4 | Registered result store read data |
| busy | output | 1 | A run is issuing or pairs are in flight |
| done | output | 1 | Last result of the run has been written |

## Verification
A carry that is lost or latched into the wrong stage shows up as a wrong result entry for the affected operand pairs. The sweep presents every one of the 256 operand pairs, so every carry pattern is exercised. A valid, last or index field that slips by a stage moves done off its exact N+5 edge or writes a sum to a neighbouring entry. The edge-by-edge done checks and the full read-back after every run expose this within the same run. Wrong issue counting shows as changed entries past N or as a done edge off by the clamped count.

// File: rtl/bpa_pkg.sv
package bpa_pkg;

    localparam int unsigned OPW     = 4;
    localparam int unsigned NUM_ENT = 16;
    localparam int unsigned IXW     = $clog2(NUM_ENT);
    localparam int unsigned CNW     = IXW + 1;

    typedef logic [OPW-1:0] word_t;
    typedef logic [IXW-1:0] idx_t;
    typedef logic [CNW-1:0] cnt_t;

    // One pipeline slot: tracking fields plus partially consumed operands
    typedef struct packed {
        logic  vld;
        logic  lst;
        idx_t  idx;
        word_t a_rem;
        word_t b_rem;
        logic  cy;
        word_t sum;
    } lane_t;

    // Returns {carry, sum} of one bit position
    function automatic logic [1:0] full_add(input logic x, input logic y, input logic ci);
        logic s;
        logic c;
        s = x ^ y ^ ci;
        c = (x & y) | (x & ci) | (y & ci);
        return {c, s};
    endfunction

    function automatic cnt_t clamp_count(input cnt_t req);
        return (req > cnt_t'(NUM_ENT)) ? cnt_t'(NUM_ENT) : req;
    endfunction

endpackage

// File: rtl/bpa_issue.sv
module bpa_issue
    import bpa_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  cnt_t count,
    input  logic pipe_busy,
    output logic iss_vld,
    output logic iss_lst,
    output idx_t iss_idx,
    output logic start_ok,
    output logic zero_run,
    output logic busy
);

    logic issuing;
    idx_t idx_q;
    cnt_t rem_q;
    cnt_t eff_cnt;

    assign eff_cnt  = clamp_count(count);
    assign busy     = issuing | pipe_busy;
    assign start_ok = start & ~busy;
    assign zero_run = start_ok & (eff_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            issuing <= 1'b0;
            idx_q   <= '0;
            rem_q   <= '0;
        end else if (start_ok) begin
            idx_q   <= '0;
            rem_q   <= eff_cnt;
            issuing <= (eff_cnt != '0);
        end else if (issuing) begin
            idx_q <= idx_q + idx_t'(1);
            rem_q <= rem_q - cnt_t'(1);
            if (rem_q == cnt_t'(1)) begin
                issuing <= 1'b0;
            end
        end
    end

    assign iss_vld = issuing;
    assign iss_lst = (rem_q == cnt_t'(1));
    assign iss_idx = idx_q;

endmodule

// File: rtl/bpa_opmem.sv
module bpa_opmem
    import bpa_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ld_en,
    input  idx_t  ld_idx,
    input  word_t ld_a,
    input  word_t ld_b,
    input  logic  iss_vld,
    input  logic  iss_lst,
    input  idx_t  iss_idx,
    output lane_t fetch
);

    word_t mem_a [NUM_ENT];
    word_t mem_b [NUM_ENT];

    always_ff @(posedge clk) begin
        if (ld_en) begin
            mem_a[ld_idx] <= ld_a;
            mem_b[ld_idx] <= ld_b;
        end
    end

    // Synchronous read stage ahead of the first cell; carry-in is zero
    always_ff @(posedge clk) begin
        if (rst) begin
            fetch <= '0;
        end else begin
            fetch.vld   <= iss_vld;
            fetch.lst   <= iss_lst;
            fetch.idx   <= iss_idx;
            fetch.a_rem <= mem_a[iss_idx];
            fetch.b_rem <= mem_b[iss_idx];
            fetch.cy    <= 1'b0;
            fetch.sum   <= '0;
        end
    end

endmodule

// File: rtl/bpa_fa_stage.sv
module bpa_fa_stage
    import bpa_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  lane_t din,
    output lane_t dout
);

    logic [1:0] cs;

    assign cs = full_add(din.a_rem[0], din.b_rem[0], din.cy);

    // Consume bit 0, shift operands down, shift new sum bit in at the top
    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else begin
            dout.vld   <= din.vld;
            dout.lst   <= din.lst;
            dout.idx   <= din.idx;
            dout.a_rem <= din.a_rem >> 1;
            dout.b_rem <= din.b_rem >> 1;
            dout.cy    <= cs[1];
            dout.sum   <= {cs[0], din.sum[OPW-1:1]};
        end
    end

endmodule

// File: rtl/bpa_resmem.sv
module bpa_resmem
    import bpa_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  logic  wr_lst,
    input  idx_t  wr_idx,
    input  word_t wr_sum,
    input  logic  start_ok,
    input  logic  zero_run,
    input  idx_t  rd_idx,
    output word_t rd_sum,
    output logic  done
);

    word_t mem_z [NUM_ENT];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_z[wr_idx] <= wr_sum;
        end
        rd_sum <= mem_z[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done <= 1'b0;
        end else if (start_ok) begin
            done <= zero_run;
        end else if (wr_en && wr_lst) begin
            done <= 1'b1;
        end
    end

endmodule

// File: rtl/bpa_top.sv
module bpa_top
    import bpa_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ld_en,
    input  logic [IXW-1:0]       ld_idx,
    input  logic [OPW-1:0]       ld_a,
    input  logic [OPW-1:0]       ld_b,
    input  logic                 start,
    input  logic [CNW-1:0]       count,
    input  logic [IXW-1:0]       rd_idx,
    output logic [OPW-1:0]       rd_sum,
    output logic                 busy,
    output logic                 done
);

    lane_t stg [OPW+1];

    logic iss_vld;
    logic iss_lst;
    idx_t iss_idx;
    logic start_ok;
    logic zero_run;
    logic pipe_busy;

    logic  tail_vld;
    logic  tail_lst;
    idx_t  tail_idx;
    word_t tail_sum;
    logic  unused_tail;

    bpa_issue u_issue (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .count     (count),
        .pipe_busy (pipe_busy),
        .iss_vld   (iss_vld),
        .iss_lst   (iss_lst),
        .iss_idx   (iss_idx),
        .start_ok  (start_ok),
        .zero_run  (zero_run),
        .busy      (busy)
    );

    bpa_opmem u_opmem (
        .clk     (clk),
        .rst     (rst),
        .ld_en   (ld_en),
        .ld_idx  (ld_idx),
        .ld_a    (ld_a),
        .ld_b    (ld_b),
        .iss_vld (iss_vld),
        .iss_lst (iss_lst),
        .iss_idx (iss_idx),
        .fetch   (stg[0])
    );

    for (genvar k = 0; k < OPW; k++) begin : g_cell
        bpa_fa_stage u_cell (
            .clk  (clk),
            .rst  (rst),
            .din  (stg[k]),
            .dout (stg[k+1])
        );
    end

    always_comb begin
        pipe_busy = 1'b0;
        for (int k = 0; k <= OPW; k++) begin
            pipe_busy = pipe_busy | stg[k].vld;
        end
    end

    assign tail_vld    = stg[OPW].vld;
    assign tail_lst    = stg[OPW].lst;
    assign tail_idx    = stg[OPW].idx;
    assign tail_sum    = stg[OPW].sum;
    // final carry and spent operand bits are dropped (mod 16 result)
    assign unused_tail = ^{stg[OPW].cy, stg[OPW].a_rem, stg[OPW].b_rem};

    bpa_resmem u_resmem (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (tail_vld),
        .wr_lst   (tail_lst),
        .wr_idx   (tail_idx),
        .wr_sum   (tail_sum),
        .start_ok (start_ok),
        .zero_run (zero_run),
        .rd_idx   (rd_idx),
        .rd_sum   (rd_sum),
        .done     (done)
    );

endmodule

// File: rtl/bpa_checker.sv
module bpa_checker
    import bpa_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic busy,
    input logic done,
    input logic wr_en,
    input logic wr_lst,
    input idx_t wr_idx
);

    // R2: results retire back to back with rising indices
    a_r2_back_to_back: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_lst) |=> (wr_en && wr_idx == idx_t'($past(wr_idx) + idx_t'(1))));

    // R3: done follows the write of the last pair
    a_r3_done_on_last: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_lst) |=> done);

    // R3: no result write while done is high
    a_r3_quiet_after_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !wr_en);

    // R9: busy is low whenever done is high
    a_r9_idle_when_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

bind bpa_top bpa_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .busy   (busy),
    .done   (done),
    .wr_en  (tail_vld),
    .wr_lst (tail_lst),
    .wr_idx (tail_idx)
);

// File: tb/test_bpa_top.sv
module test_bpa_top;
    import bpa_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ld_en = 1'b0;
    logic [3:0] ld_idx = '0;
    logic [3:0] ld_a = '0;
    logic [3:0] ld_b = '0;
    logic       start = 1'b0;
    logic [4:0] count = '0;
    logic [3:0] rd_idx = '0;
    logic [3:0] rd_sum;
    logic       busy;
    logic       done;

    int n_chk = 0;
    int n_bad = 0;
    int exp_z [16];
    int opa [16];
    int opb [16];

    always #4 clk = ~clk;

    bpa_top i_bpa_top (
        .clk    (clk),
        .rst    (rst),
        .ld_en  (ld_en),
        .ld_idx (ld_idx),
        .ld_a   (ld_a),
        .ld_b   (ld_b),
        .start  (start),
        .count  (count),
        .rd_idx (rd_idx),
        .rd_sum (rd_sum),
        .busy   (busy),
        .done   (done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic load(input int i, input int a, input int b);
        @(negedge clk);
        ld_en  = 1'b1;
        ld_idx = 4'(i);
        ld_a   = 4'(a);
        ld_b   = 4'(b);
        opa[i] = a;
        opb[i] = b;
        @(negedge clk);
        ld_en  = 1'b0;
    endtask

    // Starts a run; start edge is edge 0; optionally pulses start mid-run
    task automatic run(input int n, input bit pulse_mid);
        int eff;
        eff = (n > 16) ? 16 : n;
        @(negedge clk);
        start = 1'b1;
        count = 5'(n);
        @(negedge clk);
        start = 1'b0;
        if (eff == 0) begin
            chk(done == 1'b1, "R4 done", int'(done), 1);
            chk(busy == 1'b0, "R4 busy", int'(busy), 0);
        end else begin
            chk(done == 1'b0, "R3 cleared", int'(done), 0);
            chk(busy == 1'b1, "R9 busy", int'(busy), 1);
            for (int c = 1; c <= eff + 4; c++) begin
                if (pulse_mid && c == 3) begin
                    start = 1'b1;
                    count = 5'd2;
                end
                @(negedge clk);
                start = 1'b0;
                chk(done == 1'b0, (pulse_mid ? "R6 early" : "R2 early"), int'(done), 0);
            end
            chk(busy == 1'b1, "R9 busy late", int'(busy), 1);
            @(negedge clk);
            chk(done == 1'b1, (pulse_mid ? "R6 done" : "R2 done"), int'(done), 1);
            chk(busy == 1'b0, "R9 idle", int'(busy), 0);
            for (int i = 0; i < eff; i++) begin
                exp_z[i] = (opa[i] + opb[i]) % 16;
            end
        end
    endtask

    task automatic read_all(input string req);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            rd_idx = 4'(i);
            @(negedge clk);
            chk(int'(rd_sum) == exp_z[i], req, int'(rd_sum), exp_z[i]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) exp_z[i] = 0;
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R7 done in reset", int'(done), 0);
        chk(busy == 1'b0, "R7 busy in reset", int'(busy), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R7 done after reset", int'(done), 0);
        chk(busy == 1'b0, "R7 busy after reset", int'(busy), 0);

        // R1: every (a, b) pair across 16 full runs
        for (int r = 0; r < 16; r++) begin
            for (int i = 0; i < 16; i++) load(i, i, (i + r) % 16);
            run(16, 1'b0);
            read_all("R1");
        end

        // R3: done holds with no new start
        repeat (5) @(negedge clk);
        chk(done == 1'b1, "R3 hold", int'(done), 1);

        // R5: short run leaves upper entries alone (15+15 carries out)
        for (int i = 0; i < 16; i++) load(i, 15, 15);
        run(5, 1'b0);
        read_all("R5");

        // R4: zero count writes nothing
        for (int i = 0; i < 16; i++) load(i, 1, 2);
        run(0, 1'b0);
        read_all("R4");

        // R6: start during a run is ignored
        run(16, 1'b1);
        read_all("R6");

        // R10: oversize count clamps to 16
        for (int i = 0; i < 16; i++) load(i, i, 15);
        run(31, 1'b0);
        read_all("R10");

        // R8: read data changes only at the edge
        @(negedge clk);
        rd_idx = 4'd3;
        @(negedge clk);
        rd_idx = 4'd9;
        #1;
        chk(int'(rd_sum) == exp_z[3], "R8 hold", int'(rd_sum), exp_z[3]);
        @(negedge clk);
        chk(int'(rd_sum) == exp_z[9], "R8 update", int'(rd_sum), exp_z[9]);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule